// File: doc/BRIEF.md
# Directory Sharer Tracker with Invalidate Fan-out

This block is the home-side controller for one memory block in a directory-based coherence scheme. Each read or write request carries the ID of the processor that issues it. The controller keeps a record of which processors may hold a copy of the block. When a request makes other copies stale, it sends one invalidate request for each affected processor. A one-cycle completion pulse then tells the requester that it may continue, and the number of invalidates that were sent is reported beside that pulse.

The sharer record is chosen at elaboration by a parameter and has three forms:
- **Presence vector:** one bit per processor. This form is exact.
- **Single pointer:** records one processor only. A new reader evicts the previous one.
- **Summary bit:** a single bit meaning "somebody may hold it". A write then broadcasts an invalidate to every processor. A second parameter decides whether the writer itself is skipped.

All three forms pass their result as a kill mask to a shared fan-out engine. The engine issues invalidates one per handshake, lowest ID first. While a fan-out is in progress, new requests are refused.

Top module: `dir_sharer_ctrl`

## Requirements
- R1: After reset, `req_ready_o` is 1, `inv_valid_o` and `done_o` are 0, and `inv_count_o` is 0. The record is empty, so a first write in any mode sends no invalidates.
- R2: In presence-vector mode, a read sends no invalidate and adds the reader to the record.
- R3: In presence-vector mode, a write sends one invalidate to each recorded processor other than the writer.
- R4: In pointer mode, a read by a processor other than the recorded one sends exactly one invalidate, addressed to the recorded one, and the reader then replaces it. A read by the recorded processor sends none. Reads that alternate between two processors therefore cost one invalidate per switch.
- R5: In pointer mode, a write sends one invalidate to the recorded processor, unless that processor is the writer or the record is empty.
- R6: In summary-bit mode, reads never send invalidates, and any accepted request sets the bit. A write while the bit is set sends invalidates to all N_PROC processors. When SKIP_WRITER is 1, the writer is excluded, giving N_PROC-1. A write while the bit is clear sends none.
- R7: After a write, only the writer is recorded. In vector and pointer modes, a later write by another processor invalidates just the earlier writer.
- R8: Invalidates go out in strictly ascending ID order, one per cycle in which `inv_valid_o` and `inv_ready_i` are both high. While `inv_ready_i` is low, `inv_valid_o` and `inv_id_o` hold steady.
- R9: `done_o` is high for exactly one cycle. That cycle follows either the final invalidate handshake or, when no invalidate is needed, the acceptance edge. `inv_count_o` equals the number of handshaken invalidates during that pulse and holds that value until the next pulse.
- R10: `req_ready_o` is low from the acceptance edge until after the `done_o` cycle. A request presented during that time is not taken and causes no extra invalidates or completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_id_i | input | $clog2(N_PROC) | Requesting processor |
| inv_valid_o | output | 1 | Invalidate request present |
| inv_ready_i | input | 1 | Network takes the invalidate |
| inv_id_o | output | $clog2(N_PROC) | Processor to invalidate |
| done_o | output | 1 | One-cycle completion pulse for the current request |
| inv_count_o | output | $clog2(N_PROC+1) | Invalidates sent for the last completed request |

## Verification
- **Acceptance edge:** after it, the first invalidate is visible in the next cycle. When no invalidate is needed, `done_o` is visible in that cycle instead.
- **Invalidates:** each one retires on an edge where `inv_ready_i` was high. `done_o` and the final count follow one cycle after the last of these edges, and `req_ready_o` returns one cycle after that.
- **Bench timing:** the bench changes `inv_ready_i` just after the rising edge and samples every output on the falling edge. A handshake it counts is therefore the one the next edge retires.
- **Bench ordering:** it compares counts only once each instance has shown its completion pulse, and the next request is presented only after every instance is idle again.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        ENC_VECTOR  = 2'd0,
        ENC_POINTER = 2'd1,
        ENC_GLOBAL  = 2'd2
    } enc_e;

    typedef enum logic [1:0] {
        FO_IDLE = 2'd0,
        FO_SEND = 2'd1,
        FO_DONE = 2'd2
    } fo_e;

endpackage

// File: rtl/dir_lowest_pick.sv
module dir_lowest_pick #(
    parameter int N    = 64,
    parameter int ID_W = $clog2(N)
) (
    input  logic [N-1:0]    mask_i,
    output logic            any_o,
    output logic [ID_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = ID_W'(i);
        end
        any_o = |mask_i;
    end

endmodule

// File: rtl/dir_sharer_map.sv
module dir_sharer_map
    import dir_pkg::*;
#(
    parameter enc_e ENC_MODE    = ENC_VECTOR,
    parameter int   N           = 64,
    parameter int   ID_W        = $clog2(N),
    parameter bit   SKIP_WRITER = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_rd_i,
    input  logic            take_wr_i,
    input  logic [ID_W-1:0] id_i,
    output logic [N-1:0]    kill_mask_o
);

    logic [N-1:0] self_bit;
    assign self_bit = N'(1) << id_i;

    generate
        if (ENC_MODE == ENC_VECTOR) begin : g_vec
            typedef struct packed {
                logic [N-1:0] pres;
            } vec_st_t;
            vec_st_t st_d, st_q;

            always_comb begin
                st_d        = st_q;
                kill_mask_o = '0;
                if (take_wr_i) begin
                    kill_mask_o = st_q.pres & ~self_bit;
                    st_d.pres   = self_bit;
                end else if (take_rd_i) begin
                    st_d.pres   = st_q.pres | self_bit;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            // a read never adds stale copies to kill
            AST_VEC_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                take_rd_i |-> (kill_mask_o == '0)); // R2
        end else if (ENC_MODE == ENC_POINTER) begin : g_ptr
            typedef struct packed {
                logic            valid;
                logic [ID_W-1:0] ptr;
            } ptr_st_t;
            ptr_st_t st_d, st_q;

            always_comb begin
                st_d        = st_q;
                kill_mask_o = '0;
                if (take_rd_i || take_wr_i) begin
                    if (st_q.valid && (st_q.ptr != id_i))
                        kill_mask_o = N'(1) << st_q.ptr;
                    st_d.valid = 1'b1;
                    st_d.ptr   = id_i;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            AST_PTR_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(kill_mask_o) <= 1); // R4
        end else begin : g_glb
            typedef struct packed {
                logic hit;
            } glb_st_t;
            glb_st_t st_d, st_q;

            always_comb begin
                st_d        = st_q;
                kill_mask_o = '0;
                if (take_wr_i && st_q.hit)
                    kill_mask_o = SKIP_WRITER ? ~self_bit : {N{1'b1}};
                if (take_rd_i || take_wr_i)
                    st_d.hit = 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            AST_GLB_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                take_rd_i |-> (kill_mask_o == '0)); // R6
        end
    endgenerate

endmodule

// File: rtl/dir_inv_fanout.sv
module dir_inv_fanout
    import dir_pkg::*;
#(
    parameter int N     = 64,
    parameter int ID_W  = $clog2(N),
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [N-1:0]     mask_i,
    input  logic             inv_ready_i,
    output logic             inv_valid_o,
    output logic [ID_W-1:0]  inv_id_o,
    output logic             idle_o,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        fo_e              st;
        logic [N-1:0]     pend;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
    } fo_st_t;

    fo_st_t          st_d, st_q;
    logic            pick_any;
    logic [ID_W-1:0] pick_idx;
    logic [N-1:0]    pend_left;

    dir_lowest_pick #(.N(N), .ID_W(ID_W)) u_pick (
        .mask_i (st_q.pend),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    assign pend_left = st_q.pend & ~(N'(1) << pick_idx);

    always_comb begin
        st_d = st_q;
        case (st_q.st)
            FO_IDLE: begin
                if (load_i) begin
                    st_d.pend = mask_i;
                    st_d.cnt  = '0;
                    if (|mask_i) begin
                        st_d.st = FO_SEND;
                    end else begin
                        st_d.st   = FO_DONE;
                        st_d.last = '0;
                    end
                end
            end
            FO_SEND: begin
                if (inv_ready_i) begin
                    st_d.pend = pend_left;
                    st_d.cnt  = st_q.cnt + CNT_W'(1);
                    if (pend_left == '0) begin
                        st_d.st   = FO_DONE;
                        st_d.last = st_q.cnt + CNT_W'(1);
                    end
                end
            end
            FO_DONE: st_d.st = FO_IDLE;
            default: st_d.st = FO_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.st   <= FO_IDLE;
            st_q.pend <= '0;
            st_q.cnt  <= '0;
            st_q.last <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inv_valid_o = (st_q.st == FO_SEND) && pick_any;
    assign inv_id_o    = pick_idx;
    assign idle_o      = (st_q.st == FO_IDLE);
    assign done_o      = (st_q.st == FO_DONE);
    assign count_o     = st_q.last;

    AST_SEND_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == FO_SEND) |-> pick_any); // R8
    AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid_o && !inv_ready_i) |=> (inv_valid_o && $stable(inv_id_o))); // R8
    AST_INV_RISING_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid_o && $past(inv_valid_o && inv_ready_i)) |-> (inv_id_o > $past(inv_id_o))); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

endmodule

// File: rtl/dir_sharer_ctrl.sv
module dir_sharer_ctrl
    import dir_pkg::*;
#(
    parameter enc_e ENC_MODE    = ENC_VECTOR,
    parameter int   N_PROC      = 64,
    parameter bit   SKIP_WRITER = 1'b1,
    localparam int  ID_W        = $clog2(N_PROC),
    localparam int  CNT_W       = $clog2(N_PROC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic             req_write_i,
    input  logic [ID_W-1:0]  req_id_i,
    output logic             inv_valid_o,
    input  logic             inv_ready_i,
    output logic [ID_W-1:0]  inv_id_o,
    output logic             done_o,
    output logic [CNT_W-1:0] inv_count_o
);

    logic              fo_idle;
    logic              take;
    logic [N_PROC-1:0] kill_mask;

    assign take        = req_valid_i && fo_idle;
    assign req_ready_o = fo_idle;

    dir_sharer_map #(
        .ENC_MODE    (ENC_MODE),
        .N           (N_PROC),
        .ID_W        (ID_W),
        .SKIP_WRITER (SKIP_WRITER)
    ) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_rd_i   (take && !req_write_i),
        .take_wr_i   (take && req_write_i),
        .id_i        (req_id_i),
        .kill_mask_o (kill_mask)
    );

    dir_inv_fanout #(
        .N     (N_PROC),
        .ID_W  (ID_W),
        .CNT_W (CNT_W)
    ) u_fan (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (take),
        .mask_i      (kill_mask),
        .inv_ready_i (inv_ready_i),
        .inv_valid_o (inv_valid_o),
        .inv_id_o    (inv_id_o),
        .idle_o      (fo_idle),
        .done_o      (done_o),
        .count_o     (inv_count_o)
    );

    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid_o || done_o) |-> !req_ready_o); // R10
    AST_TAKE_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o); // R10
    AST_QUIET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !req_write_i && (ENC_MODE != ENC_POINTER))
        |=> (done_o && !inv_valid_o)); // R9

endmodule

// File: tb/sim_dir_sharer_ctrl.sv
`timescale 1ns/1ps
module sim_dir_sharer_ctrl;
    import dir_pkg::*;

    localparam int N    = 64;
    localparam int ID_W = 6;
    localparam int CW   = 7;
    localparam int NI   = 4;
    localparam int NV   = 11;

    // columns: write, id, vector count, pointer count, pointer victim, summary count (writer skipped)
    localparam int VECS [NV][6] = '{
        '{0,  0, 0, 0, -1,  0},
        '{0,  1, 0, 1,  0,  0},
        '{0,  0, 0, 1,  1,  0},
        '{1,  2, 2, 1,  0, 63},
        '{1,  2, 0, 0, -1, 63},
        '{0,  5, 0, 1,  2,  0},
        '{0,  5, 0, 0, -1,  0},
        '{0, 63, 0, 1,  5,  0},
        '{1,  0, 3, 1, 63, 63},
        '{1, 63, 1, 1,  0, 63},
        '{0, 63, 0, 0, -1,  0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid [NI];
    logic            req_write = 1'b0;
    logic [ID_W-1:0] req_id = '0;
    logic            inv_ready = 1'b1;
    logic            req_ready [NI];
    logic            inv_valid [NI];
    logic [ID_W-1:0] inv_id    [NI];
    logic            done      [NI];
    logic [CW-1:0]   inv_cnt   [NI];

    int total = 0;
    int bad   = 0;
    int hs_cnt [NI];
    int done_seen [NI];
    int last_id [NI];
    int prev_id [NI];
    bit hold_pend [NI];
    logic [ID_W-1:0] hold_id [NI];
    int rdy_ctr = 0;

    always #2.5 clk = ~clk;

    dir_sharer_ctrl #(.ENC_MODE(ENC_VECTOR),  .N_PROC(N), .SKIP_WRITER(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid[0]), .req_ready_o(req_ready[0]),
        .req_write_i(req_write), .req_id_i(req_id), .inv_valid_o(inv_valid[0]),
        .inv_ready_i(inv_ready), .inv_id_o(inv_id[0]), .done_o(done[0]), .inv_count_o(inv_cnt[0]));
    dir_sharer_ctrl #(.ENC_MODE(ENC_POINTER), .N_PROC(N), .SKIP_WRITER(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid[1]), .req_ready_o(req_ready[1]),
        .req_write_i(req_write), .req_id_i(req_id), .inv_valid_o(inv_valid[1]),
        .inv_ready_i(inv_ready), .inv_id_o(inv_id[1]), .done_o(done[1]), .inv_count_o(inv_cnt[1]));
    dir_sharer_ctrl #(.ENC_MODE(ENC_GLOBAL),  .N_PROC(N), .SKIP_WRITER(1'b1)) u2 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid[2]), .req_ready_o(req_ready[2]),
        .req_write_i(req_write), .req_id_i(req_id), .inv_valid_o(inv_valid[2]),
        .inv_ready_i(inv_ready), .inv_id_o(inv_id[2]), .done_o(done[2]), .inv_count_o(inv_cnt[2]));
    dir_sharer_ctrl #(.ENC_MODE(ENC_GLOBAL),  .N_PROC(N), .SKIP_WRITER(1'b0)) u3 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid[3]), .req_ready_o(req_ready[3]),
        .req_write_i(req_write), .req_id_i(req_id), .inv_valid_o(inv_valid[3]),
        .inv_ready_i(inv_ready), .inv_id_o(inv_id[3]), .done_o(done[3]), .inv_count_o(inv_cnt[3]));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // back-pressure pattern, changed just after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            rdy_ctr++;
            inv_ready = (rdy_ctr % 4) != 1;
        end
    end

    // per-instance monitor, sampling on the falling edge
    initial begin
        for (int k = 0; k < NI; k++) begin
            hs_cnt[k] = 0; done_seen[k] = 0; last_id[k] = -1; prev_id[k] = -1;
            hold_pend[k] = 1'b0; hold_id[k] = '0;
        end
        forever begin
            @(negedge clk);
            for (int k = 0; k < NI; k++) begin
                if (!rst_n) begin
                    hs_cnt[k] = 0; prev_id[k] = -1; hold_pend[k] = 1'b0;
                end else begin
                    if (hold_pend[k])
                        chk(inv_valid[k] && inv_id[k] == hold_id[k], "R8 hold while stalled",
                            int'(inv_id[k]), int'(hold_id[k]));
                    hold_pend[k] = inv_valid[k] && !inv_ready;
                    hold_id[k]   = inv_id[k];
                    if (inv_valid[k] && inv_ready) begin
                        chk(int'(inv_id[k]) > prev_id[k], "R8 ascending order",
                            int'(inv_id[k]), prev_id[k] + 1);
                        prev_id[k] = int'(inv_id[k]);
                        last_id[k] = int'(inv_id[k]);
                        hs_cnt[k]++;
                    end
                    if (done[k]) begin
                        chk(int'(inv_cnt[k]) == hs_cnt[k], "R9 count matches handshakes",
                            int'(inv_cnt[k]), hs_cnt[k]);
                        done_seen[k]++;
                        hs_cnt[k]  = 0;
                        prev_id[k] = -1;
                    end
                end
            end
        end
    end

    task automatic issue(input bit wr, input int id, output bit hung);
        int base [NI];
        int wd;
        hung = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            base[k] = done_seen[k];
            last_id[k] = -1;
            req_valid[k] = 1'b1;
        end
        req_write = wr;
        req_id = ID_W'(id);
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < NI; k++) req_valid[k] = 1'b0;
        wd = 0;
        while ((done_seen[0] == base[0] || done_seen[1] == base[1] ||
                done_seen[2] == base[2] || done_seen[3] == base[3]) && wd < 3000) begin
            @(negedge clk);
            wd++;
        end
        if (wd >= 3000) begin
            hung = 1'b1;
            chk(1'b0, "watchdog", wd, 0);
        end
        @(negedge clk);
    endtask

    initial begin
        bit hung;
        int base2;
        int wd;
        for (int k = 0; k < NI; k++) req_valid[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int k = 0; k < NI; k++) begin
            chk(req_ready[k] && !inv_valid[k] && !done[k] && inv_cnt[k] == '0,
                "R1 reset state", int'(inv_cnt[k]) + (req_ready[k] ? 0 : 100), 0);
        end

        // table walk: R2 R3 R4 R5 R6 R7
        hung = 1'b0;
        for (int v = 0; v < NV && !hung; v++) begin
            int e3;
            issue(VECS[v][0] != 0, VECS[v][1], hung);
            e3 = (VECS[v][5] == 0) ? 0 : N;
            chk(int'(inv_cnt[0]) == VECS[v][2], VECS[v][0] ? "R3 vector write count" : "R2 vector read count",
                int'(inv_cnt[0]), VECS[v][2]);
            chk(int'(inv_cnt[1]) == VECS[v][3], VECS[v][0] ? "R5 pointer write count" : "R4 pointer read count",
                int'(inv_cnt[1]), VECS[v][3]);
            if (VECS[v][3] == 1)
                chk(last_id[1] == VECS[v][4], "R4 pointer victim id", last_id[1], VECS[v][4]);
            chk(int'(inv_cnt[2]) == VECS[v][5], "R6 summary count skip writer",
                int'(inv_cnt[2]), VECS[v][5]);
            chk(int'(inv_cnt[3]) == e3, "R6 summary count all processors",
                int'(inv_cnt[3]), e3);
        end
        // R7: after the write by 63 (row 10) the pointer and vector records held only 63; row 11 confirmed it

        // R10: refused request while the summary-bit instance fans out
        @(negedge clk);
        base2 = done_seen[2];
        req_valid[2] = 1'b1;
        req_write = 1'b1;
        req_id = ID_W'(1);
        @(posedge clk);
        @(negedge clk);
        req_id = ID_W'(9);
        wd = 0;
        while (done_seen[2] == base2 && wd < 3000) begin
            chk(!req_ready[2], "R10 ready low during fan-out", int'(req_ready[2]), 0);
            @(negedge clk);
            wd++;
        end
        req_valid[2] = 1'b0;
        if (wd >= 3000) chk(1'b0, "watchdog", wd, 0);
        chk(int'(inv_cnt[2]) == N - 1, "R6 broadcast count", int'(inv_cnt[2]), N - 1);
        repeat (6) begin
            @(negedge clk);
            chk(!inv_valid[2] && !done[2], "R10 refused request left no work",
                int'(inv_valid[2]) + int'(done[2]), 0);
        end
        chk(done_seen[2] == base2 + 1, "R10 single completion", done_seen[2], base2 + 1);

        // R1: fresh record after reset, first write sends nothing in every mode
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        issue(1'b1, 7, hung);
        for (int k = 0; k < NI; k++)
            chk(inv_cnt[k] == '0, "R1 first write after reset", int'(inv_cnt[k]), 0);
        // R7: writer 7 is the only holder; write by 8 invalidates just 7
        issue(1'b1, 8, hung);
        chk(int'(inv_cnt[0]) == 1 && last_id[0] == 7, "R7 vector owner only", last_id[0], 7);
        chk(int'(inv_cnt[1]) == 1 && last_id[1] == 7, "R7 pointer owner only", last_id[1], 7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule